// File: doc/BRIEF.md
# Transmit Time-Slice Gate

This block decides whether the frame at the head of a transmit queue may go out on the air right now. It runs two periodic windows, slice 0 and slice 1, and each window is tied to one peer station. Every slice has a cycle length, an opening offset and a closing offset, all counted in microseconds. A microsecond strobe advances both slice counters. Each counter returns to zero after its last microsecond.

Each slice also holds a 32-bit peer tag, which is the low four bytes of a 48-bit destination MAC. For 6c:fd:b9:4c:b1:c1 the tag is 0xb94cb1c1. The low 32 bits of the head frame's destination are compared against both tags. The frame takes the window of the slice whose tag matches. Software programs the slices through a simple write port. Any write into a slice restarts that slice's cycle, so a new setting always begins from offset zero.

The block is purely a gate. Queue storage, frame assembly and carrier sensing are handled elsewhere.

Top module: `tsg_top`

## Requirements
- R1: After reset every slice register and both counters are zero. Each window then covers offset 0 of a one-microsecond cycle, so `slice_open` is 2'b11 and `tx_grant` is 1.
- R2: A write with `wr_en` high selects the slice with `wr_sel[2]` (0 or 1) and the register with `wr_sel[1:0]`. The codes are: 0 = cycle length minus one, 1 = first open microsecond, 2 = last open microsecond, 3 = peer tag. The register loads `wr_data` at the clock edge.
- R3: A slice counter advances by one at each clock edge where `us_tick` is high. It holds its value at every edge where `us_tick` is low.
- R4: A counter that equals its cycle-length register returns to zero on the next strobe. A length value of L therefore gives a period of L+1 strobes.
- R5: `slice_open[i]` is high exactly when counter i lies between the first-open and last-open registers of slice i, with both bounds included.
- R6: When a slice's first-open value is greater than its last-open value, that slice's window never opens.
- R7: A write to any register of a slice clears that slice's counter at the same edge, and this takes priority over a strobe in that cycle. The other slice's counter is not affected.
- R8: When only slice 1's tag equals `dst_lo`, `tx_grant` equals `slice_open[1]`.
- R9: When slice 0's tag equals `dst_lo`, or when neither tag does, `tx_grant` equals `slice_open[0]`. This includes the case where both tags match.
- R10: The two slices count and open independently, each with its own period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle microsecond strobe |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Bit 2 picks the slice; bits 1:0 pick the register |
| wr_data | input | 32 | Write data |
| dst_lo | input | 32 | Low 32 bits of the head frame's destination MAC |
| slice_open | output | 2 | Window-open flag for each slice |
| tx_grant | output | 1 | Transmit permission for the head frame |

## Verification
The bench gives the two slices periods of 10 and 5 microseconds and walks them through both wraps.

- A counter that wraps one step late, or a window test that drops a bound, shows up as a wrong flag at the boundary offsets.
- A strobe that arrives in the same cycle as a configuration write is aimed at the clear: a design that lets the strobe win resumes counting from 1 instead of 0.
- Giving both slices the same tag exposes a selector that prefers slice 1.
- An inverted window, with its first-open offset past its last-open offset, catches a comparator that wraps around instead of staying shut.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

  localparam int TSG_WORD_W = 32;

  typedef enum logic [1:0] {
    FLD_PERIOD = 2'd0,
    FLD_OPEN   = 2'd1,
    FLD_CLOSE  = 2'd2,
    FLD_PEER   = 2'd3
  } tsg_field_e;

  // next counter value on a strobe: wrap after the cycle-length value
  function automatic logic [TSG_WORD_W-1:0] tsg_next_count(
    input logic [TSG_WORD_W-1:0] cnt,
    input logic [TSG_WORD_W-1:0] last
  );
    if (cnt >= last) return '0;
    return cnt + 1'b1;
  endfunction

  // inclusive window membership
  function automatic logic tsg_in_window(
    input logic [TSG_WORD_W-1:0] cnt,
    input logic [TSG_WORD_W-1:0] first,
    input logic [TSG_WORD_W-1:0] final_us
  );
    return (cnt >= first) && (cnt <= final_us);
  endfunction

endpackage

// File: rtl/tsg_slice.sv
module tsg_slice
  import tsg_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              cfg_we,
  input  tsg_field_e        cfg_field,
  input  logic [31:0]       cfg_data,
  output logic              open,
  output logic [ADDR_W-1:0] peer
);

  logic [CNT_W-1:0] period_q, open_at_q, close_at_q, cnt_q;
  logic [CNT_W-1:0] cnt_step;
  logic             wrap_evt, step_evt, clear_evt;

  assign clear_evt = cfg_we;
  assign step_evt  = us_tick && !cfg_we;
  assign wrap_evt  = step_evt && (cnt_q == period_q);
  assign cnt_step  = CNT_W'(tsg_next_count(32'(cnt_q), 32'(period_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q   <= '0;
      open_at_q  <= '0;
      close_at_q <= '0;
      peer       <= '0;
    end else if (cfg_we) begin
      unique case (cfg_field)
        FLD_PERIOD: period_q   <= cfg_data[CNT_W-1:0];
        FLD_OPEN:   open_at_q  <= cfg_data[CNT_W-1:0];
        FLD_CLOSE:  close_at_q <= cfg_data[CNT_W-1:0];
        FLD_PEER:   peer       <= cfg_data[ADDR_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clear_evt) cnt_q <= '0;
    else if (step_evt)  cnt_q <= cnt_step;
  end

  assign open = tsg_in_window(32'(cnt_q), 32'(open_at_q), 32'(close_at_q));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !wrap_evt) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!us_tick && !cfg_we) |=> $stable(cnt_q));
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt_q == '0));
  assert_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= period_q);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (cnt_q == '0));
  assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (open_at_q > close_at_q) |-> !open);

endmodule

// File: rtl/tsg_match.sv
module tsg_match #(
  parameter int ADDR_W = 32,
  parameter int N_SL   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        dst,
  input  logic [N_SL*ADDR_W-1:0]   peers,
  input  logic [N_SL-1:0]          opens,
  output logic                     grant
);

  logic [N_SL-1:0] hit;
  logic            pick_one;

  for (genvar g = 0; g < N_SL; g++) begin : g_cmp
    assign hit[g] = (peers[g*ADDR_W +: ADDR_W] == dst);
  end

  // slice 0 wins ties and is the fallback
  assign pick_one = hit[1] && !hit[0];
  assign grant    = pick_one ? opens[1] : opens[0];

  assert_pick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (peers[2*ADDR_W-1:ADDR_W] == dst && peers[ADDR_W-1:0] != dst) |-> (grant == opens[1]));
  assert_default_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (peers[ADDR_W-1:0] == dst || peers[2*ADDR_W-1:ADDR_W] != dst) |-> (grant == opens[0]));

endmodule

// File: rtl/tsg_top.sv
module tsg_top
  import tsg_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [31:0] dst_lo,
  output logic [1:0]  slice_open,
  output logic        tx_grant
);

  localparam int N_SL = 2;

  logic [N_SL-1:0]        we_vec;
  logic [N_SL*ADDR_W-1:0] peer_flat;
  tsg_field_e             field;

  assign field = tsg_field_e'(wr_sel[1:0]);

  for (genvar g = 0; g < N_SL; g++) begin : g_slice
    assign we_vec[g] = wr_en && (wr_sel[2] == 1'(g));
    tsg_slice #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_slice (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
      .cfg_we(we_vec[g]), .cfg_field(field), .cfg_data(wr_data),
      .open(slice_open[g]), .peer(peer_flat[g*ADDR_W +: ADDR_W])
    );
  end

  tsg_match #(.ADDR_W(ADDR_W), .N_SL(N_SL)) u_match (
    .clk(clk), .rst_n(rst_n), .dst(dst_lo[ADDR_W-1:0]),
    .peers(peer_flat), .opens(slice_open), .grant(tx_grant)
  );

  assert_onewrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));
  assert_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (we_vec == '0));

endmodule

// File: tb/tsg_top_test.sv
module tsg_top_test;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        us_tick = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] dst_lo = 0;
  logic [1:0]  slice_open;
  logic        tx_grant;

  int n_run = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [31:0] T0 = 32'hb94cb1c1;
  localparam logic [31:0] T1 = 32'h0000beef;
  localparam logic [31:0] TX = 32'h12345678;

  // ticks to apply, destination, expected {open1, open0, grant}
  localparam int          V_N = 10;
  localparam int          V_TK  [V_N] = '{0, 2, 1, 1, 1, 1, 3, 1, 3, 9};
  localparam logic [31:0] V_DST [V_N] = '{T0, T1, T1, TX, T1, T0, T1, T0, TX, T1};
  localparam logic [2:0]  V_EXP [V_N] = '{3'b000, 3'b010, 3'b111, 3'b111, 3'b010,
                                          3'b000, 3'b101, 3'b000, 3'b111, 3'b010};

  always #4 clk = ~clk;

  tsg_top uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .dst_lo(dst_lo),
    .slice_open(slice_open), .tx_grant(tx_grant)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // each strobe is followed by an idle cycle, so holding is exercised (R3)
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); us_tick = 1;
      @(negedge clk); us_tick = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 open", 32'(slice_open), 32'h3);
    chk("R1 grant", 32'(tx_grant), 32'h1);

    // R2 configuration: slice 0 period 10, window 2..5; slice 1 period 5, window 3..4
    wr(3'b000, 9);  wr(3'b001, 2);  wr(3'b010, 5);  wr(3'b011, T0);
    wr(3'b100, 4);  wr(3'b101, 3);  wr(3'b110, 4);  wr(3'b111, T1);

    // table walk: R3 R4 R5 R8 R9 R10
    for (int v = 0; v < V_N; v++) begin
      ticks(V_TK[v]);
      dst_lo = V_DST[v];
      #1;
      chk($sformatf("R5_R10 vec%0d open", v), 32'(slice_open), 32'(V_EXP[v][2:1]));
      chk($sformatf("R8_R9 vec%0d grant", v), 32'(tx_grant), 32'(V_EXP[v][0]));
    end
    // counters now: slice 0 at 2, slice 1 at 2

    // R7: write slice 1 only; slice 0 keeps its count
    wr(3'b101, 3);
    ticks(3);          // slice 0 -> 5 (open), slice 1 -> 3 (open)
    chk("R7 other slice kept", 32'(slice_open), 32'h3);

    // R7: write and strobe in the same cycle, clear wins
    @(negedge clk);
    wr_en = 1; wr_sel = 3'b010; wr_data = 5; us_tick = 1;
    @(negedge clk);
    wr_en = 0; us_tick = 0;
    chk("R7 cleared open0", 32'(slice_open[0]), 32'h0);
    ticks(1);          // slice 0 at 1: closed (2 would be open)
    chk("R7 clear beats strobe", 32'(slice_open[0]), 32'h0);

    // R9: both tags equal, slice 0 wins
    wr(3'b111, T0);    // slice 1 counter -> 0
    ticks(2);          // slice 0 at 3 open, slice 1 at 2 closed
    dst_lo = T0;
    #1;
    chk("R9 tie open", 32'(slice_open), 32'h1);
    chk("R9 tie grant", 32'(tx_grant), 32'h1);

    // R6: inverted window on slice 1 never opens over a full period
    wr(3'b101, 4);
    wr(3'b110, 2);
    for (int k = 0; k < 6; k++) begin
      chk($sformatf("R6 inverted step%0d", k), 32'(slice_open[1]), 32'h0);
      ticks(1);
    end

    // R4: length 0 means the counter stays at 0 every strobe
    wr(3'b100, 0); wr(3'b101, 0); wr(3'b110, 0);
    ticks(3);
    chk("R4 length zero", 32'(slice_open[1]), 32'h1);

    // R1: reset again restores the defaults
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    dst_lo = TX;
    #1;
    chk("R1 re-reset open", 32'(slice_open), 32'h3);
    chk("R1 re-reset grant", 32'(tx_grant), 32'h1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule